// File: doc/BRIEF.md
# Stereo Pixel Splitter and Duplicator

This block accepts one 24-bit RGB pixel stream, together with its horizontal sync, vertical sync and data-enable. It feeds two panels from one 48-bit output word. Bus A is bits [23:0] and bus B is bits [47:24]. A beat is valid only in a cycle where `out_valid` is high.

In stereo mode the incoming line carries the two eyes interleaved one pixel at a time: left, right, left, right. Each left/right pair leaves the block as one beat, with the left pixel on bus A and the right pixel on bus B. Beats therefore arrive at half the input pixel rate. For 1920x1080 active per eye with 1936 clocks per line, a stereo input line holds 3872 pixel clocks. In mono mode every input pixel is copied to both buses, and every input cycle produces a beat.

The pairing restarts on every line, so the first active pixel of a line is always treated as a left pixel. A line whose active length is odd in stereo mode flushes its last pixel on bus A with bus B set to zero, and it latches a sticky error flag. The requested mode is adopted only at a vertical sync leading edge, so no frame is ever handled in two modes. Sync and data-enable travel with the pixel data they belong to.

Top module: `stereo_pix_split`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `out_valid`, `out_de`, `out_hs`, `out_vs`, `out_pix`, `pair_err` and `stereo_active` are all 0. The active mode after reset is mono.
- R2: In stereo mode, an active pixel pair P1,P2 produces one beat with `out_pix[23:0]`=P1 and `out_pix[47:24]`=P2, and `out_de`=1. The beat appears in the cycle after P2 is presented. The cycle after P1 carries no beat.
- R3: In stereo mode two consecutive cycles never both carry a beat. During blanking, beats continue every other cycle with `out_de`=0 and `out_pix`=0.
- R4: In mono mode every cycle produces a beat one cycle after its input. For an active pixel P, both halves of `out_pix` equal P and `out_de`=1. For a blank input, `out_pix`=0 and `out_de`=0.
- R5: The first active pixel after a low-to-high transition of `in_de` always goes to bus A, whatever the number of blanking cycles before it.
- R6: In stereo mode, if `in_de` falls after an odd number of active pixels, then in the cycle after the fall a beat carries the unpaired pixel on bus A, zero on bus B, and `out_de`=1. `pair_err` then rises and stays high until reset.
- R7: `out_hs` and `out_vs` of a beat equal `in_hs` and `in_vs` in the input cycle that completes the beat. In stereo mode that cycle is the second pixel of the pair. In mono mode it is the single input cycle.
- R8: `mode_req` takes effect only at a rising edge of `in_vs`. `stereo_active` reports the mode used for the current beat and changes only in the cycle after the cycle in which `in_vs` rises.
- R9: `out_de` is high only on beats that carry at least one active pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_req | input | 1 | Requested mode: 1 stereo, 0 mono |
| in_hs | input | 1 | Input horizontal sync |
| in_vs | input | 1 | Input vertical sync, active high |
| in_de | input | 1 | Input data-enable |
| in_pix | input | 24 | Input RGB pixel |
| out_valid | output | 1 | Output beat strobe |
| out_hs | output | 1 | Horizontal sync aligned to the beat |
| out_vs | output | 1 | Vertical sync aligned to the beat |
| out_de | output | 1 | Beat carries active pixel data |
| out_pix | output | 48 | Bus A in [23:0], bus B in [47:24] |
| stereo_active | output | 1 | Mode used for the current beat |
| pair_err | output | 1 | Sticky flag: an odd-length stereo line was seen |

## Verification
The assertions assume that `in_vs` rises only while `in_de` is low. They also assume that every line is separated from the next by at least one cycle of low data-enable, so each line has a distinct rising edge for the pairing restart. The bench keeps to both assumptions: it changes mode only through a blank vertical sync pulse, and it always follows each active burst with blanking cycles. Inputs are driven on the falling clock edge, so the block only ever sees stable synchronous levels.

// File: rtl/stereo_pix_split.sv
module stereo_pix_split #(
  parameter int PW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_req,
  input  logic          in_hs,
  input  logic          in_vs,
  input  logic          in_de,
  input  logic [PW-1:0] in_pix,
  output logic          out_valid,
  output logic          out_hs,
  output logic          out_vs,
  output logic          out_de,
  output logic [2*PW-1:0] out_pix,
  output logic          stereo_active,
  output logic          pair_err
);

  localparam int OW = 2 * PW;

  logic          mode_act;
  logic          vs_q, de_q;
  logic          ph;
  logic [PW-1:0] hold;

  logic          de_rise, vs_rise;
  logic          beat, dsel, flush, take;
  logic [OW-1:0] data;

  assign de_rise = in_de & ~de_q;
  assign vs_rise = in_vs & ~vs_q;
  assign take    = mode_act & in_de & (de_rise | ~ph);

  always_comb begin
    beat  = 1'b0;
    dsel  = 1'b0;
    flush = 1'b0;
    data  = '0;
    if (!mode_act) begin
      beat = 1'b1;
      dsel = in_de;
      data = in_de ? {in_pix, in_pix} : '0;
    end else if (in_de) begin
      if (!de_rise && ph) begin
        beat = 1'b1;
        dsel = 1'b1;
        data = {in_pix, hold};
      end
    end else if (ph) begin
      beat  = 1'b1;
      dsel  = de_q;
      flush = de_q;
      data  = de_q ? {{PW{1'b0}}, hold} : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_act <= 1'b0;
      vs_q     <= 1'b0;
      de_q     <= 1'b0;
      ph       <= 1'b0;
      hold     <= '0;
    end else begin
      vs_q <= in_vs;
      de_q <= in_de;
      if (vs_rise) mode_act <= mode_req;
      if (take) hold <= in_pix;
      if (vs_rise || !mode_act) ph <= 1'b0;
      else if (de_rise)         ph <= 1'b1;
      else                      ph <= ~ph;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      out_hs        <= 1'b0;
      out_vs        <= 1'b0;
      out_de        <= 1'b0;
      out_pix       <= '0;
      stereo_active <= 1'b0;
      pair_err      <= 1'b0;
    end else begin
      out_valid     <= beat;
      out_de        <= beat & dsel;
      stereo_active <= mode_act;
      if (flush) pair_err <= 1'b1;
      if (beat) begin
        out_hs  <= in_hs;
        out_vs  <= in_vs;
        out_pix <= data;
      end
    end
  end

  p_half_rate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && stereo_active) |=> !(out_valid && stereo_active));

  p_mono_dup_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !stereo_active) |-> (out_pix[OW-1:PW] == out_pix[PW-1:0]));

  p_first_left_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_act && in_de && !de_q) |=> !out_valid);

  p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pair_err) |-> pair_err);

  p_mode_at_vs_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode_act) |-> $past(in_vs && !vs_q));

  p_de_on_beat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stereo_active && in_de && !de_q && !$past(out_valid)) |=> !out_de);

endmodule

// File: tb/stereo_pix_split_test.sv
module stereo_pix_split_test;
  localparam time PERIOD = 10ns;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        mode_req = 0;
  logic        in_hs = 0, in_vs = 0, in_de = 0;
  logic [23:0] in_pix = 0;
  logic        out_valid, out_hs, out_vs, out_de, stereo_active, pair_err;
  logic [47:0] out_pix;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(PERIOD/2) clk = ~clk;

  stereo_pix_split uut (
    .clk(clk), .rst_n(rst_n), .mode_req(mode_req),
    .in_hs(in_hs), .in_vs(in_vs), .in_de(in_de), .in_pix(in_pix),
    .out_valid(out_valid), .out_hs(out_hs), .out_vs(out_vs), .out_de(out_de),
    .out_pix(out_pix), .stereo_active(stereo_active), .pair_err(pair_err)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(logic de, logic hs, logic vs, logic [23:0] pix);
    @(negedge clk);
    in_de = de; in_hs = hs; in_vs = vs; in_pix = pix;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; mode_req = 0;
    in_de = 0; in_hs = 0; in_vs = 0; in_pix = 0;
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic enter_mode(logic m);
    mode_req = m;
    cyc(0, 0, 1, 0);
    cyc(0, 0, 0, 0);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 valid", out_valid, 0);
    chk("R1 pix", out_pix, 0);
    chk("R1 flags", {out_de, out_hs, out_vs, stereo_active, pair_err}, 0);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;
    chk("R1 mono after reset", stereo_active, 0);
  endtask

  task automatic t_mono();
    cyc(1, 0, 0, 24'hA1B2C3);
    chk("R4 valid", out_valid, 1);
    chk("R4 dup", out_pix, {24'hA1B2C3, 24'hA1B2C3});
    chk("R4 de", out_de, 1);
    cyc(1, 1, 0, 24'h123456);
    chk("R4 dup2", out_pix, {24'h123456, 24'h123456});
    chk("R7 mono hs", out_hs, 1);
    cyc(0, 0, 0, 24'hFFFFFF);
    chk("R4 blank", {out_valid, out_de, out_pix}, {1'b1, 1'b0, 48'h0});
    chk("R9 mono blank de", out_de, 0);
  endtask

  task automatic t_mode_switch();
    mode_req = 1;
    cyc(0, 0, 0, 0);
    cyc(0, 0, 0, 0);
    chk("R8 no change before vs", stereo_active, 0);
    chk("R8 still mono valid", out_valid, 1);
    cyc(0, 0, 1, 0);
    chk("R8 vs cycle old mode", stereo_active, 0);
    cyc(0, 0, 0, 0);
    chk("R8 new mode after vs", stereo_active, 1);
  endtask

  task automatic t_stereo_line(int lead);
    int nv;
    for (int i = 0; i < lead; i++) cyc(0, 0, 0, 0);
    cyc(1, 0, 0, 24'h111111);
    chk("R5 no beat on first", out_valid, 0);
    cyc(1, 1, 0, 24'h222222);
    chk("R2 pair", out_pix, {24'h222222, 24'h111111});
    chk("R2 de", {out_valid, out_de}, 2'b11);
    chk("R7 stereo hs", out_hs, 1);
    cyc(1, 0, 0, 24'h333333);
    chk("R3 no back-to-back", out_valid, 0);
    cyc(1, 0, 0, 24'h444444);
    chk("R2 pair2", out_pix, {24'h444444, 24'h333333});
    chk("R7 stereo hs low", out_hs, 0);
    cyc(0, 0, 0, 0);
    chk("R6 even line no flush", {out_valid, pair_err}, 0);
    nv = 0;
    for (int i = 0; i < 4; i++) begin
      cyc(0, 0, 0, 0);
      if (out_valid) begin
        nv++;
        chk("R3 blank beat", {out_de, out_pix}, 0);
      end
    end
    chk("R3 blank rate", nv, 2);
  endtask

  task automatic t_odd_line();
    cyc(1, 0, 0, 24'hAAAAAA);
    cyc(1, 0, 0, 24'hBBBBBB);
    cyc(1, 0, 0, 24'hCCCCCC);
    chk("R6 err before fall", pair_err, 0);
    cyc(0, 0, 0, 0);
    chk("R6 flush beat", {out_valid, out_de}, 2'b11);
    chk("R6 flush data", out_pix, {24'h000000, 24'hCCCCCC});
    chk("R6 err set", pair_err, 1);
    repeat (3) cyc(0, 0, 0, 0);
    chk("R6 err sticky", pair_err, 1);
    cyc(1, 0, 0, 24'h010203);
    cyc(1, 0, 0, 24'h040506);
    chk("R5 realign after odd", out_pix, {24'h040506, 24'h010203});
  endtask

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_mono();
    t_mode_switch();
    t_stereo_line(1);
    t_stereo_line(2);
    t_stereo_line(3);
    t_odd_line();
    do_reset();
    @(negedge clk); rst_n = 1;
    enter_mode(1);
    t_stereo_line(2);
    enter_mode(0);
    t_mono();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule